// File: doc/BRIEF.md
# Multi-channel start-stop interval digitizer

This block times up to eight intervals at once against a shared start. When a rising edge on the common start pin is accepted, a single counter is cleared and starts counting core clock cycles. Each channel keeps the counter value at the first rising edge on its own stop pin and ignores every later edge until the next start. The result is the number of clock cycles between the two pin edges. Because the counter is reset by the start itself, the result does not depend on where the start falls against any free-running phase.

A cycle ends early once every channel has stopped. Otherwise it ends when the counter reaches the full-scale count chosen by a 2-bit range input. At that point any channel still waiting is marked as overflowed. A common stop pin acts as a stop on all channels together. A fast clear pin aborts the cycle at any point. An inhibit level blocks new starts. A self-test trigger runs a cycle with no external pins and stops every channel at four fifths of full scale. A register stage or a readout block further on reads the flattened result bus, the overflow flags, a one-cycle done strobe and a flag that is set when no stop was seen.

Top module: `interval_digitizer`

## Requirements
- R1: After reset, every result is 0, every overflow flag is 0, the done strobe is 0 and the empty flag (`no_stops`) is 1.
- R2: If the start pin rises before clock edge k and a channel's stop pin rises before edge k+D, that channel's result is D, where 1 <= D <= full scale - 1. Channel n occupies `result[n*11 +: 11]`.
- R3: A channel records only the first stop edge after an accepted start. Stop edges that come before the start, or while no cycle is running, change nothing.
- R4: A rising edge on the common stop pin acts as a stop on every channel that has not stopped yet.
- R5: `range_sel` picks the full scale: 00 gives 2048 counts, 01 gives 1024, and 10 or 11 gives 512. A channel with no stop when the counter reaches full scale - 1 gets overflow=1 and result = full scale - 1. A stop that lands on that same count wins, and no overflow is set.
- R6: `done` is high for exactly one cycle per completed measurement. A measurement is complete when all channels have stopped or when full scale is reached.
- R7: A rising edge on fast clear, at any time, clears all results and overflow flags and returns the block to idle. The aborted cycle raises no `done`.
- R8: A start edge that arrives while `inhibit_in` is high is ignored.
- R9: A rising edge on `self_test_in` while idle starts a cycle. At count floor(4*full scale/5) every channel stops: 1638 at range 00, 819 at range 01 and 409 at range 10 or 11.
- R10: Each time a measurement completes, `no_stops` is updated to 1 if no channel took a stop and to 0 otherwise. It keeps that value through fast clears and through ignored starts.
- R11: A start edge that arrives while a cycle is running is ignored, and the running counter keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_in | input | 1 | Common start, rising edge used |
| stop_in | input | 8 | Per-channel stop, rising edge used |
| common_stop_in | input | 1 | Stop for all channels together |
| fast_clear_in | input | 1 | Aborts the cycle and clears results |
| inhibit_in | input | 1 | Level that blocks start edges |
| self_test_in | input | 1 | Rising edge runs the self-test cycle |
| range_sel | input | 2 | Full-scale selection |
| result | output | 88 | Eight 11-bit interval counts, channel 0 in the low bits |
| overflow | output | 8 | Per-channel full-scale-reached flag |
| done | output | 1 | One-cycle end-of-measurement strobe |
| no_stops | output | 1 | Last completed measurement saw no stops |

## Verification
The bench aims at the edges of the count window. A stop at exactly full scale - 1 must be kept with no overflow. A stop one count later must turn into an overflow, and a design that compared off by one would flag the first case or record the second. Other checks cover a stop held high from before the start, a second stop pulse, and a start re-armed in mid-cycle. A design that armed on levels, or that restarted the counter, would report wrong counts in those cases. Fast clear in mid-cycle and starts under inhibit must leave no done strobe and no data. A leaky design would show a done pulse or nonzero results. The self-test counts at two ranges catch a wrong threshold formula.

// File: rtl/tdc_pkg.sv
// Shared definitions for the interval digitizer.
// Assumes range codes 2'b10 and 2'b11 both select the shortest range.
package tdc_pkg;

    typedef enum logic {
        TB_IDLE = 1'b0,
        TB_RUN  = 1'b1
    } tb_state_e;

    // Right-shift applied to the maximum count for a given range code.
    function automatic int unsigned range_shift(input logic [1:0] sel);
        case (sel)
            2'b00:   return 0;
            2'b01:   return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/tdc_edge_sync.sv
// Two-flop synchronizer with a third flop for rising-edge detection.
// Assumes every input is asynchronous to clk and stays high for at least two cycles.
module tdc_edge_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] meta_q, sync_q, prev_q;

    // Synchronizer chain plus the delayed copy used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Each bit pulses high for one cycle after its synchronized input goes from 0 to 1.
    assign rise = sync_q & ~prev_q;

endmodule

// File: rtl/tdc_timebase.sv
// Shared counter and cycle control. The counter is loaded with 1 on the edge
// that accepts a start, so it is in phase with the start. Also latches the
// range and self-test settings and produces the end-of-cycle strobe.
// Assumes channel stop flags are valid whenever busy is high.
module tdc_timebase
    import tdc_pkg::*;
#(
    parameter int RES_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             test_req,
    input  logic             clr,
    input  logic             all_quiet,
    input  logic [1:0]       range_sel,
    output logic             busy,
    output logic             start_go,
    output logic [RES_W-1:0] count,
    output logic [RES_W-1:0] fs_max,
    output logic             at_full,
    output logic             test_fire,
    output logic             done
);
    localparam int PW = RES_W + 3;

    tb_state_e        state_q;
    logic [RES_W-1:0] fs_last, thr, thr_q;
    logic [PW-1:0]    fs_x4;
    logic             test_q, done_d;

    // Decode the range code into the last count and the self-test threshold.
    always_comb begin
        fs_last = {RES_W{1'b1}} >> range_shift(range_sel);
        fs_x4   = ({3'b000, fs_last} + PW'(1)) << 2;
        thr     = RES_W'(fs_x4 / PW'(5));
    end

    // Decide whether a start is accepted and whether the cycle finishes.
    always_comb begin
        busy      = (state_q == TB_RUN);
        start_go  = !busy && !clr && (start_req || test_req);
        at_full   = busy && (count == fs_max);
        test_fire = busy && test_q && (count == thr_q);
        done_d    = busy && !clr && (all_quiet || at_full);
    end

    // State, counter and latched settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TB_IDLE;
            count   <= '0;
            fs_max  <= '0;
            thr_q   <= '0;
            test_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= done_d;
            if (clr) begin
                state_q <= TB_IDLE;
                count   <= '0;
            end else if (start_go) begin
                state_q <= TB_RUN;
                count   <= RES_W'(1);
                fs_max  <= fs_last;
                thr_q   <= thr;
                test_q  <= test_req;
            end else if (done_d) begin
                state_q <= TB_IDLE;
            end else if (busy) begin
                count <= count + RES_W'(1);
            end
        end
    end

endmodule

// File: rtl/tdc_channel.sv
// One measurement channel. It arms on an accepted start, keeps the count at
// its first stop event, and saturates with an overflow flag at full scale.
// Assumes stop_ev already merges the own, common and self-test stops.
module tdc_channel #(
    parameter int RES_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start_go,
    input  logic             stop_ev,
    input  logic             at_full,
    input  logic [RES_W-1:0] count,
    input  logic [RES_W-1:0] fs_max,
    output logic [RES_W-1:0] result,
    output logic             ovf,
    output logic             got,
    output logic             pending
);
    logic armed_q, hit;

    // A stop is taken only while armed; pending means still waiting after this cycle.
    always_comb begin
        hit     = armed_q && stop_ev;
        pending = armed_q && !stop_ev;
    end

    // Arm, capture and saturate; fast clear has the highest priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            armed_q <= 1'b0;
            result  <= '0;
            ovf     <= 1'b0;
            got     <= 1'b0;
        end else if (start_go) begin
            armed_q <= 1'b1;
            result  <= '0;
            ovf     <= 1'b0;
            got     <= 1'b0;
        end else if (hit) begin
            armed_q <= 1'b0;
            result  <= count;
            got     <= 1'b1;
        end else if (armed_q && at_full) begin
            armed_q <= 1'b0;
            result  <= fs_max;
            ovf     <= 1'b1;
        end
    end

endmodule

// File: rtl/interval_digitizer.sv
// Top of the multi-channel start-stop interval digitizer. It synchronizes
// all pins, shares one start-aligned counter among NUM_CH channels and keeps
// the empty-measurement flag. Assumes all inputs are asynchronous levels.
module interval_digitizer #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_in,
    input  logic [NUM_CH-1:0]       stop_in,
    input  logic                    common_stop_in,
    input  logic                    fast_clear_in,
    input  logic                    inhibit_in,
    input  logic                    self_test_in,
    input  logic [1:0]              range_sel,
    output logic [NUM_CH*RES_W-1:0] result,
    output logic [NUM_CH-1:0]       overflow,
    output logic                    done,
    output logic                    no_stops
);
    localparam int SW = NUM_CH + 4;

    logic [SW-1:0]     rise;
    logic [NUM_CH-1:0] stop_rise, got, pending;
    logic              cstop_rise, start_rise, clr_rise, test_rise;
    logic              inh_meta_q, inh_q;
    logic              tb_busy, start_go, at_full, test_fire;
    logic [RES_W-1:0]  count, fs_max;

    tdc_edge_sync #(.WIDTH(SW)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({self_test_in, fast_clear_in, start_in, common_stop_in, stop_in}),
        .rise     (rise)
    );

    // Split the edge vector into named strobes.
    assign {test_rise, clr_rise, start_rise, cstop_rise, stop_rise} = rise;

    // Two-flop synchronizer for the inhibit level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_meta_q <= 1'b0;
            inh_q      <= 1'b0;
        end else begin
            inh_meta_q <= inhibit_in;
            inh_q      <= inh_meta_q;
        end
    end

    tdc_timebase #(.RES_W(RES_W)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_rise && !inh_q),
        .test_req  (test_rise),
        .clr       (clr_rise),
        .all_quiet (~|pending),
        .range_sel (range_sel),
        .busy      (tb_busy),
        .start_go  (start_go),
        .count     (count),
        .fs_max    (fs_max),
        .at_full   (at_full),
        .test_fire (test_fire),
        .done      (done)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        tdc_channel #(.RES_W(RES_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr_rise),
            .start_go (start_go),
            .stop_ev  (stop_rise[ch] || cstop_rise || test_fire),
            .at_full  (at_full),
            .count    (count),
            .fs_max   (fs_max),
            .result   (result[ch*RES_W +: RES_W]),
            .ovf      (overflow[ch]),
            .got      (got[ch]),
            .pending  (pending[ch])
        );
    end

    // Update the empty flag one cycle after each completed measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            no_stops <= 1'b1;
        end else if (done) begin
            no_stops <= ~|got;
        end
    end

endmodule

// File: rtl/tdc_checker.sv
// Temporal checks on the interval digitizer, attached through bind.
module tdc_checker #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 11
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    done,
    input logic                    busy,
    input logic                    start_go,
    input logic                    clr_ev,
    input logic [NUM_CH-1:0]       overflow,
    input logic [NUM_CH*RES_W-1:0] result
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy)); // R6
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clr_ev |=> (overflow == '0 && result == '0)); // R7
    AST_CLEAR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) clr_ev |=> !done); // R7
    AST_OVF_AT_END: assert property (@(posedge clk) disable iff (!rst_n) (|(overflow & ~$past(overflow))) |-> done); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !clr_ev && !start_go) |=> $stable(result)); // R3
endmodule

bind interval_digitizer tdc_checker #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_tdc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .busy     (tb_busy),
    .start_go (start_go),
    .clr_ev   (clr_rise),
    .overflow (overflow),
    .result   (result)
);

// File: tb/test_interval_digitizer.sv
`timescale 1ns/1ps
module test_interval_digitizer;
    localparam int NCH = 8;
    localparam int RW  = 11;
    localparam int NV  = 6;

    // Vector table: range, common-stop delay, per-channel stop delays (0 = none).
    localparam logic [1:0]  V_RNG [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1};
    localparam logic [11:0] V_CS  [NV] = '{12'd0, 12'd0, 12'd300, 12'd0, 12'd7, 12'd0};
    localparam logic [95:0] V_DL  [NV] = '{
        {12'd2047, 12'd2000, 12'd1000, 12'd500, 12'd100, 12'd3, 12'd2, 12'd1},
        {12'd40, 12'd30, 12'd20, 12'd10, 12'd1024, 12'd1023, 12'd0, 12'd5},
        {12'd50, 12'd511, 12'd0, 12'd301, 12'd300, 12'd299, 12'd0, 12'd100},
        {96'd0},
        {96'd0},
        {12'd64, 12'd64, 12'd64, 12'd64, 12'd64, 12'd64, 12'd64, 12'd64}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_in = 1'b0, common_stop_in = 1'b0, fast_clear_in = 1'b0;
    logic inhibit_in = 1'b0, self_test_in = 1'b0;
    logic [NCH-1:0] stop_in = '0;
    logic [1:0] range_sel = 2'b00;
    logic [NCH*RW-1:0] result;
    logic [NCH-1:0] overflow;
    logic done, no_stops;
    int checks = 0, fails = 0, done_cnt = 0;

    always #5 clk = ~clk;

    interval_digitizer i_interval_digitizer (
        .clk(clk), .rst_n(rst_n), .start_in(start_in), .stop_in(stop_in),
        .common_stop_in(common_stop_in), .fast_clear_in(fast_clear_in),
        .inhibit_in(inhibit_in), .self_test_in(self_test_in), .range_sel(range_sel),
        .result(result), .overflow(overflow), .done(done), .no_stops(no_stops));

    // Count done strobes seen at clock edges.
    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int fs_of(input logic [1:0] r);
        return (r == 2'd0) ? 2048 : (r == 2'd1) ? 1024 : 512;
    endfunction

    task automatic idle_low(input int n);
        start_in = 0; stop_in = '0; common_stop_in = 0; fast_clear_in = 0; self_test_in = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_all(input string req, input int val, input int ovf);
        for (int ch = 0; ch < NCH; ch++) begin
            chk(req, int'(result[ch*RW +: RW]), val);
            chk(req, int'(overflow[ch]), ovf);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog R6: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk_all("R1 reset", 0, 0);
        chk("R1 done", int'(done), 0);
        chk("R1 no_stops", int'(no_stops), 1);

        // Table walk: R2 R4 R5 R6 R10
        for (int v = 0; v < NV; v++) begin
            int fs, any, e, d, cs;
            fs = fs_of(V_RNG[v]);
            cs = int'(V_CS[v]);
            range_sel = V_RNG[v];
            done_cnt = 0;
            start_in = 1;
            for (int t = 0; t <= fs + 6; t++) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    d = int'(V_DL[v][ch*12 +: 12]);
                    stop_in[ch] = (d != 0 && t >= d);
                end
                common_stop_in = (cs != 0 && t >= cs);
                @(negedge clk);
            end
            idle_low(4);
            any = 0;
            for (int ch = 0; ch < NCH; ch++) begin
                d = int'(V_DL[v][ch*12 +: 12]);
                e = (d == 0) ? 99999 : d;
                if (cs != 0 && cs < e) e = cs;
                if (e <= fs - 1) begin
                    any = 1;
                    chk("R2/R4 result", int'(result[ch*RW +: RW]), e);
                    chk("R5 no overflow", int'(overflow[ch]), 0);
                end else begin
                    chk("R5 saturated result", int'(result[ch*RW +: RW]), fs - 1);
                    chk("R5 overflow flag", int'(overflow[ch]), 1);
                end
            end
            chk("R6 done count", done_cnt, 1);
            chk("R10 no_stops", int'(no_stops), any ? 0 : 1);
        end

        // R3 and R11: stop held before start, double stop pulse, start re-armed mid-cycle
        range_sel = 2'd2;
        done_cnt = 0;
        stop_in[0] = 1;
        repeat (4) @(negedge clk);
        for (int t = 0; t <= 518; t++) begin
            start_in = !(t >= 5 && t < 30);
            stop_in[1] = (t >= 10 && t < 12) || (t >= 20);
            @(negedge clk);
        end
        idle_low(4);
        chk("R3 first stop kept", int'(result[RW +: RW]), 10);
        chk("R3 early stop ignored", int'(overflow[0]), 1);
        chk("R3 early stop result", int'(result[RW-1:0]), 511);
        chk("R11 single done", done_cnt, 1);

        // R7 fast clear mid-cycle
        done_cnt = 0;
        for (int t = 0; t <= 518; t++) begin
            start_in = 1;
            stop_in[0] = (t >= 10);
            fast_clear_in = (t >= 50 && t < 53);
            @(negedge clk);
        end
        idle_low(4);
        chk_all("R7 cleared", 0, 0);
        chk("R7 no done", done_cnt, 0);
        chk("R10 holds over clear", int'(no_stops), 0);

        // R8 inhibit blocks start
        inhibit_in = 1;
        done_cnt = 0;
        repeat (4) @(negedge clk);
        for (int t = 0; t <= 518; t++) begin
            start_in = 1;
            stop_in[0] = (t >= 10);
            @(negedge clk);
        end
        idle_low(4);
        inhibit_in = 0;
        repeat (4) @(negedge clk);
        chk("R8 no done", done_cnt, 0);
        chk("R8 result untouched", int'(result[RW-1:0]), 0);

        // R9 self-test at two ranges
        for (int r = 0; r < 2; r++) begin
            range_sel = 2'(r);
            done_cnt = 0;
            self_test_in = 1;
            repeat (3) @(negedge clk);
            self_test_in = 0;
            repeat (fs_of(2'(r)) + 8) @(negedge clk);
            chk_all("R9 self-test", (r == 0) ? 1638 : 819, 0);
            chk("R9 done", done_cnt, 1);
            chk("R9 no_stops", int'(no_stops), 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule